// File: doc/BRIEF.md
# Call and Return Stack Frame Sequencer

This block performs the memory half of subroutine entry, subroutine exit and software-trap entry for a 32-bit core. The decode stage hands it one request together with the current program counter, stack pointer and frame pointer. The block then walks a three-word stack frame over a single-word request/ready memory port. When it finishes, it returns the new program counter, stack pointer and frame pointer with a one-cycle completion strobe.

Each frame has three words. Counting down from the caller's stack pointer, they are an unused slot kept for a static chain, the return address, and the caller's frame pointer. Entry steps the stack pointer down past the unused slot without touching memory. It writes the return address one word lower and the old frame pointer one word below that. After entry, both pointers name the lowest word.

Exit takes the opposite path, starting from the frame pointer rather than the stack pointer. It reads the saved frame pointer and then the return address. It leaves the stack pointer three words above where it started.

Top module: `frame_seq`

## Requirements
- R1: On reqKind 0 (absolute call) with aligned pointers, the block issues two word writes. The first stores reqPc+6 at reqSp-8, and the second stores reqFp at reqSp-12. It then reports newSp = newFp = reqSp-12 and newPc = reqTarget.
- R2: On reqKind 1 (register call), the frame is built exactly as in R1, except that the stored return address is reqPc+2.
- R3: On reqKind 3 (trap entry), the frame is built as in R1 with return address reqPc+6, and newPc is the handler address given on reqTarget.
- R4: On reqKind 2 (return), the block issues two word reads, first at reqFp and then at reqFp+4. It reports newFp = the word read at reqFp, newPc = the word read at reqFp+4, and newSp = reqFp+12.
- R5: A memory access completes only in a cycle where memReq and memReady are both high. While memReady is low, memReq, memWe, memAddr and memWdata hold their values.
- R6: reqReady is high only when the block is idle. A reqValid presented while reqReady is low is ignored: it causes no extra memory access and does not change the result of the operation in flight.
- R7: A request whose reqSp or reqFp has a nonzero value in bits [1:0] is refused. alignErr pulses for one cycle, no memory access is made, done stays low, and newPc/newSp/newFp keep their previous values. Every address the block presents is a multiple of 4.
- R8: After reset, reqReady is 1, memReq, done and alignErr are 0, and newPc, newSp and newFp are 0.
- R9: Each accepted aligned request yields exactly one single-cycle done pulse, in the cycle after its last memory handshake. newPc, newSp and newFp hold their values until the next done.
- R10: Each accepted aligned request makes exactly two memory accesses, in the order stated in R1 to R4. No access occurs while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqKind | input | 2 | 0 absolute call, 1 register call, 2 return, 3 trap entry |
| reqPc | input | 32 | Address of the call or trap instruction |
| reqTarget | input | 32 | Call target or trap handler address |
| reqSp | input | 32 | Stack pointer at request time |
| reqFp | input | 32 | Frame pointer at request time |
| reqReady | output | 1 | Block is idle and can take a request |
| memReq | output | 1 | Memory access pending |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | 32 | Word address of the access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memReady |
| memReady | input | 1 | Memory completes the access this cycle |
| done | output | 1 | One-cycle completion strobe |
| alignErr | output | 1 | One-cycle refusal strobe for misaligned pointers |
| newPc | output | 32 | Program counter after the operation |
| newSp | output | 32 | Stack pointer after the operation |
| newFp | output | 32 | Frame pointer after the operation |

## Verification
The bench targets the following corner cases and the faulty behaviour each would expose:
- Return address offset: a design that used the wrong offset for register calls would store reqPc+6 where reqPc+2 belongs.
- Unwind base: a return that started from reqSp instead of reqFp would read the wrong words. The bench checks this with a call followed by a return through the frame just built, which must give back the caller's stack pointer and frame pointer.
- Memory stalls: memReady is withheld at random, so a sequencer that advanced or changed its address without a handshake would log extra or misplaced accesses.
- Requests while busy: junk requests are presented while busy, and a sequencer that took them would disturb the frame.
- Misalignment: misaligned pointers on each request kind must produce a refusal with no memory traffic and unchanged outputs.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  typedef enum logic [1:0] {
    KIND_CALL_ABS = 2'd0,
    KIND_CALL_REG = 2'd1,
    KIND_RETURN   = 2'd2,
    KIND_TRAP     = 2'd3
  } reqKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_RA,
    ST_PUSH_FP,
    ST_POP_FP,
    ST_POP_RA
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;      // capture request operands
    logic stepDown;   // working pointer down one word
    logic takeFp;     // capture popped frame pointer, step up one word
    logic commit;     // update the result registers
    logic selFpData;  // write data is the saved frame pointer
    logic retMode;    // operation is a return
  } dpCtl_t;

endpackage

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       misaligned,
  input  logic       memReady,
  output logic       reqReady,
  output logic       memReq,
  output logic       memWe,
  output dpCtl_t     dpCtl,
  output logic       done,
  output logic       alignErr
);

  seqState_e state, stateNext;
  logic retLatched;
  logic alignNext;
  logic isReturnReq;

  assign isReturnReq = (reqKind == KIND_RETURN);
  assign reqReady    = (state == ST_IDLE);

  always_comb begin
    stateNext     = state;
    dpCtl         = '0;
    dpCtl.retMode = retLatched;
    memReq        = 1'b0;
    memWe         = 1'b0;
    alignNext     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (misaligned) begin
            alignNext = 1'b1;
          end else begin
            dpCtl.latch   = 1'b1;
            dpCtl.retMode = isReturnReq;
            stateNext     = isReturnReq ? ST_POP_FP : ST_PUSH_RA;
          end
        end
      end
      ST_PUSH_RA: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) begin
          dpCtl.stepDown = 1'b1;
          stateNext      = ST_PUSH_FP;
        end
      end
      ST_PUSH_FP: begin
        memReq          = 1'b1;
        memWe           = 1'b1;
        dpCtl.selFpData = 1'b1;
        if (memReady) begin
          dpCtl.commit = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      ST_POP_FP: begin
        memReq = 1'b1;
        if (memReady) begin
          dpCtl.takeFp = 1'b1;
          stateNext    = ST_POP_RA;
        end
      end
      ST_POP_RA: begin
        memReq = 1'b1;
        if (memReady) begin
          dpCtl.commit = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      retLatched <= 1'b0;
      done       <= 1'b0;
      alignErr   <= 1'b0;
    end else begin
      state    <= stateNext;
      done     <= dpCtl.commit;
      alignErr <= alignNext;
      if (dpCtl.latch) retLatched <= isReturnReq;
    end
  end

  // R9: completion strobe lasts one cycle
  p_done_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: no request is taken while memory traffic is pending
  p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady);

  // R7: a refusal carries no traffic and no completion
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> (!done && !memReq));

  // R10: after completion the sequencer is idle
  p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (reqReady && !memReq));

endmodule

// File: rtl/frame_seq_dp.sv
module frame_seq_dp
  import frame_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SHORT_LEN = 2,
  parameter int LONG_LEN  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqPc,
  input  logic [ADDR_W-1:0] reqTarget,
  input  logic [ADDR_W-1:0] reqSp,
  input  logic [ADDR_W-1:0] reqFp,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              misaligned,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] newSp,
  output logic [ADDR_W-1:0] newFp
);

  localparam int WORD_BYTES = ADDR_W / 8;
  localparam int ALIGN_BITS = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] ONE_WORD  = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] TWO_WORDS = ADDR_W'(2 * WORD_BYTES);
  localparam logic [ADDR_W-1:0] SHORT_INC = ADDR_W'(SHORT_LEN);
  localparam logic [ADDR_W-1:0] LONG_INC  = ADDR_W'(LONG_LEN);

  logic [ADDR_W-1:0] workSp;
  logic [ADDR_W-1:0] retAddr;
  logic [ADDR_W-1:0] jumpTo;
  logic [ADDR_W-1:0] keptFp;
  logic [ADDR_W-1:0] poppedFp;

  assign misaligned = (|reqSp[ALIGN_BITS-1:0]) | (|reqFp[ALIGN_BITS-1:0]);
  assign memAddr    = workSp;
  assign memWdata   = dpCtl.selFpData ? keptFp : retAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workSp   <= '0;
      retAddr  <= '0;
      jumpTo   <= '0;
      keptFp   <= '0;
      poppedFp <= '0;
      newPc    <= '0;
      newSp    <= '0;
      newFp    <= '0;
    end else begin
      if (dpCtl.latch) begin
        // entry skips the unused slot in the same step that aims at the return slot
        workSp  <= dpCtl.retMode ? reqFp : (reqSp - TWO_WORDS);
        retAddr <= reqPc + ((reqKind == KIND_CALL_REG) ? SHORT_INC : LONG_INC);
        jumpTo  <= reqTarget;
        keptFp  <= reqFp;
      end
      if (dpCtl.stepDown) workSp <= workSp - ONE_WORD;
      if (dpCtl.takeFp) begin
        poppedFp <= memRdata;
        workSp   <= workSp + ONE_WORD;
      end
      if (dpCtl.commit) begin
        if (dpCtl.retMode) begin
          newPc <= memRdata;
          newFp <= poppedFp;
          newSp <= workSp + TWO_WORDS;
        end else begin
          newPc <= jumpTo;
          newSp <= workSp;
          newFp <= workSp;
        end
      end
    end
  end

  // R9: results move only on commit
  p_results_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.commit |=> ($stable(newPc) && $stable(newSp) && $stable(newFp)));

endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SHORT_LEN = 2,
  parameter int LONG_LEN  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqPc,
  input  logic [ADDR_W-1:0] reqTarget,
  input  logic [ADDR_W-1:0] reqSp,
  input  logic [ADDR_W-1:0] reqFp,
  output logic              reqReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic [ADDR_W-1:0] memRdata,
  input  logic              memReady,
  output logic              done,
  output logic              alignErr,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] newSp,
  output logic [ADDR_W-1:0] newFp
);

  localparam int ALIGN_BITS = $clog2(ADDR_W / 8);

  dpCtl_t dpCtl;
  logic   misaligned;

  frame_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .misaligned (misaligned),
    .memReady   (memReady),
    .reqReady   (reqReady),
    .memReq     (memReq),
    .memWe      (memWe),
    .dpCtl      (dpCtl),
    .done       (done),
    .alignErr   (alignErr)
  );

  frame_seq_dp #(
    .ADDR_W    (ADDR_W),
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtl      (dpCtl),
    .reqKind    (reqKind),
    .reqPc      (reqPc),
    .reqTarget  (reqTarget),
    .reqSp      (reqSp),
    .reqFp      (reqFp),
    .memRdata   (memRdata),
    .misaligned (misaligned),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .newPc      (newPc),
    .newSp      (newSp),
    .newFp      (newFp)
  );

  // R5: a stalled access keeps its request unchanged
  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata)));

  // R7: every presented address is word aligned
  p_addr_aligned_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[ALIGN_BITS-1:0] == '0));

endmodule

// File: tb/tb_frame_seq.sv
module tb_frame_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  reqKind;
  logic [31:0] reqPc, reqTarget, reqSp, reqFp;
  logic        reqReady, memReq, memWe, memReady, done, alignErr;
  logic [31:0] memAddr, memWdata, memRdata, newPc, newSp, newFp;

  always #10 clk = ~clk;  // 50 MHz

  frame_seq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqPc(reqPc), .reqTarget(reqTarget), .reqSp(reqSp), .reqFp(reqFp),
    .reqReady(reqReady), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .done(done), .alignErr(alignErr), .newPc(newPc), .newSp(newSp), .newFp(newFp)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] logAddr [8];
  logic [31:0] logData [8];
  logic        logWe   [8];
  int          logCount = 0;
  int          doneCnt  = 0;
  int          errCnt   = 0;
  int          holdErr  = 0;
  bit          fastMem  = 1'b0;

  logic        capReq = 1'b0, capReady = 1'b0, capWe = 1'b0;
  logic [31:0] capAddr = '0, capData = '0;

  // memory model and monitor, evaluated between clock edges
  always @(negedge clk) begin
    if (!rstN) begin
      capReq = 1'b0;
    end else begin
      if (capReq && capReady) begin
        if (logCount < 8) begin
          logAddr[logCount] = capAddr;
          logData[logCount] = capWe ? capData : 32'h0;
          logWe[logCount]   = capWe;
        end
        logCount++;
        if (capWe) mem[capAddr] = capData;
      end
      if (capReq && !capReady &&
          (memReq !== 1'b1 || memAddr !== capAddr || memWe !== capWe || memWdata !== capData))
        holdErr++;
      if (done)     doneCnt++;
      if (alignErr) errCnt++;
      capReq  = memReq;
      capAddr = memAddr;
      capWe   = memWe;
      capData = memWdata;
    end
    memReady = fastMem ? 1'b1 : (($urandom % 3) != 0);
    capReady = memReady;
    memRdata = mem.exists(memAddr) ? mem[memAddr] : (memAddr ^ 32'h5A5A0000);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic runOp(input logic [1:0] kind, input logic [31:0] pc, input logic [31:0] tgt,
                       input logic [31:0] sp, input logic [31:0] fp, input bit intrude,
                       input string tag);
    logic [31:0] prevPc, prevSp, prevFp, expRet, expNewPc, expNewFp, expNewSp;
    bit misal;
    int waitN;
    misal  = (sp[1:0] != 2'b00) || (fp[1:0] != 2'b00);
    prevPc = newPc;
    prevSp = newSp;
    prevFp = newFp;
    expNewPc = tgt;
    expNewFp = sp - 32'd12;
    expNewSp = sp - 32'd12;
    expRet   = pc + ((kind == 2'd1) ? 32'd2 : 32'd6);
    if (kind == 2'd2) begin
      expNewFp = $urandom & 32'hFFFF_FFFC;
      expNewPc = $urandom;
      mem[fp]          = expNewFp;
      mem[fp + 32'd4]  = expNewPc;
      expNewSp = fp + 32'd12;
    end
    waitN = 0;
    while (!reqReady && waitN < 400) begin tick(); waitN++; end
    logCount = 0; doneCnt = 0; errCnt = 0;
    reqValid = 1'b1; reqKind = kind; reqPc = pc; reqTarget = tgt; reqSp = sp; reqFp = fp;
    tick();
    reqValid = 1'b0;
    waitN = 0;
    while (doneCnt == 0 && errCnt == 0 && waitN < 400) begin
      if (intrude) begin
        reqValid  = !reqReady;
        reqKind   = 2'($urandom);
        reqSp     = $urandom;
        reqFp     = $urandom;
        reqPc     = $urandom;
        reqTarget = $urandom;
      end
      tick();
      waitN++;
    end
    reqValid = 1'b0;
    repeat (3) tick();
    if (misal) begin
      chk({tag, " R7 alignErr pulses"}, 32'(errCnt), 32'd1);
      chk({tag, " R7 no done"}, 32'(doneCnt), 32'd0);
      chk({tag, " R7 no access"}, 32'(logCount), 32'd0);
      chk({tag, " R7 pc kept"}, newPc, prevPc);
      chk({tag, " R7 sp kept"}, newSp, prevSp);
      chk({tag, " R7 fp kept"}, newFp, prevFp);
    end else begin
      chk({tag, " R9 one done"}, 32'(doneCnt), 32'd1);
      chk({tag, " R10 two accesses"}, 32'(logCount), 32'd2);
      if (logCount == 2) begin
        if (kind == 2'd2) begin
          chk({tag, " R4 first read addr"}, logAddr[0], fp);
          chk({tag, " R4 first is read"}, 32'(logWe[0]), 32'd0);
          chk({tag, " R4 second read addr"}, logAddr[1], fp + 32'd4);
          chk({tag, " R4 second is read"}, 32'(logWe[1]), 32'd0);
        end else begin
          chk({tag, " R1 ra addr"}, logAddr[0], sp - 32'd8);
          chk({tag, " R1 ra write"}, 32'(logWe[0]), 32'd1);
          chk({tag, (kind == 2'd1) ? " R2 ra data" : (kind == 2'd3) ? " R3 ra data" : " R1 ra data"},
              logData[0], expRet);
          chk({tag, " R1 fp addr"}, logAddr[1], sp - 32'd12);
          chk({tag, " R1 fp write"}, 32'(logWe[1]), 32'd1);
          chk({tag, " R1 fp data"}, logData[1], fp);
        end
      end
      chk({tag, (kind == 2'd2) ? " R4 newPc" : (kind == 2'd3) ? " R3 newPc" : " R1 newPc"}, newPc, expNewPc);
      chk({tag, (kind == 2'd2) ? " R4 newSp" : " R1 newSp"}, newSp, expNewSp);
      chk({tag, (kind == 2'd2) ? " R4 newFp" : " R1 newFp"}, newFp, expNewFp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] sp0, fp0, callSp, callFp;
    void'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 1'b0; reqKind = '0; reqPc = '0; reqTarget = '0;
    reqSp = '0; reqFp = '0;
    repeat (3) tick();
    // R8 reset state
    chk("R8 reqReady", 32'(reqReady), 32'd1);
    chk("R8 memReq", 32'(memReq), 32'd0);
    chk("R8 done", 32'(done), 32'd0);
    chk("R8 alignErr", 32'(alignErr), 32'd0);
    chk("R8 newPc", newPc, 32'd0);
    chk("R8 newSp", newSp, 32'd0);
    chk("R8 newFp", newFp, 32'd0);
    rstN = 1'b1;
    tick();
    // idle: no traffic (R10)
    logCount = 0;
    repeat (5) tick();
    chk("R10 idle quiet", 32'(logCount), 32'd0);

    // directed, single-cycle memory
    fastMem = 1'b1;
    runOp(2'd0, 32'h0000_0100, 32'h0000_2000, 32'h0000_8000, 32'h0000_8100, 1'b0, "abs call R1");
    runOp(2'd1, 32'h0000_0200, 32'h0000_3000, 32'h0000_9000, 32'h0000_9100, 1'b0, "reg call R2");
    runOp(2'd3, 32'h0000_0300, 32'hE000_0040, 32'h0000_A000, 32'h0000_A010, 1'b0, "trap R3");
    runOp(2'd2, 32'h0, 32'h0, 32'h0000_1234, 32'h0000_B000, 1'b0, "return R4");
    fastMem = 1'b0;

    // round trip: return through the frame a call just built (R4)
    sp0 = 32'h0001_0000; fp0 = 32'h0001_0040;
    runOp(2'd0, 32'h0000_0400, 32'h0000_5000, sp0, fp0, 1'b0, "trip call R1");
    callSp = newSp; callFp = newFp;
    reqValid = 1'b0;
    begin
      int w = 0;
      while (!reqReady && w < 100) begin tick(); w++; end
    end
    logCount = 0; doneCnt = 0;
    reqValid = 1'b1; reqKind = 2'd2; reqSp = callSp; reqFp = callFp;
    tick();
    reqValid = 1'b0;
    begin
      int w = 0;
      while (doneCnt == 0 && w < 400) begin tick(); w++; end
    end
    repeat (2) tick();
    chk("trip R4 pc back", newPc, 32'h0000_0406);
    chk("trip R4 fp back", newFp, fp0);
    chk("trip R4 sp back", newSp, sp0);

    // misalignment, each kind (R7)
    runOp(2'd0, 32'h10, 32'h20, 32'h0000_8002, 32'h0000_8100, 1'b0, "misal sp R7");
    runOp(2'd2, 32'h10, 32'h20, 32'h0000_8000, 32'h0000_8101, 1'b0, "misal fp R7");
    runOp(2'd3, 32'h10, 32'h20, 32'h0000_8003, 32'h0000_8103, 1'b0, "misal both R7");

    // requests while busy are ignored (R6)
    runOp(2'd0, 32'h0000_0500, 32'h0000_6000, 32'h0002_0000, 32'h0002_0100, 1'b1, "busy R6");
    runOp(2'd2, 32'h0, 32'h0, 32'h0, 32'h0003_0000, 1'b1, "busy ret R6");

    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      logic [1:0] k;
      logic [31:0] s, f;
      k = 2'($urandom);
      s = $urandom & 32'hFFFF_FFFC;
      f = $urandom & 32'hFFFF_FFFC;
      if (($urandom % 8) == 0) s[1:0] = 2'($urandom % 3 + 1);
      runOp(k, $urandom, $urandom, s, f, ($urandom % 2) == 1, "random");
    end

    chk("R5 stalled request held", 32'(holdErr), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule